// File: doc/BRIEF.md
# Self-Correcting Triplicated Register

This block is a data register of configurable width hardened against single-event upsets by triplication at the flip-flop level. Each stored bit is held in three separate flip-flops. The output is the bitwise two-of-three vote of those copies. On every clock edge the voted value, or the new input when a load is requested, is written back into all three copies. Because of this feedback, a bit flipped in one copy is overwritten by the majority at the next edge, and upsets that arrive over time cannot accumulate into a failed vote.

A mismatch output is raised whenever the copies disagree in any bit. Three per-copy XOR masks let verification flip chosen stored bits at a chosen edge. Clock, reset, the data input and the voter itself are shared and are not hardened. A double upset in the same bit is outside the block's protection: it wins the vote, and the feedback then spreads it to all three copies.

Top module: `tmr_reg`

## Requirements
- R1: While rst_ni is low, all three copies hold RESET_VAL (default 8'hA5): data_o equals RESET_VAL and mismatch_o is 0.
- R2: When load_i is high at a clock edge, data_o equals the data_i sampled at that edge from then on.
- R3: When load_i is low and no fault is injected, data_o keeps its value at every edge.
- R4: Bit b of data_o is 1 exactly when at least two of the three copies hold 1 in bit b.
- R5: An upset confined to one copy in a given bit never changes data_o, whether the register loads or holds at that edge.
- R6: A copy corrupted at one edge is rewritten with the voted value at the next edge, even with load_i low. The repair can be seen because a later single upset of the same bit in another copy leaves data_o unchanged.
- R7: mismatch_o is 1 in the cycle after any edge that leaves the copies in disagreement in at least one bit. It is 0 in the cycle after an edge at which no mask bit was set.
- R8: Single-copy upsets spread over different bits, whether in one edge or in successive edges, are each corrected and never combine into an output error.
- R9: If two copies of the same bit are flipped at one edge, data_o takes the inverted value of that bit. After the following edge all copies hold that corrupted value and mismatch_o returns to 0.
- R10: A set bit in flipK_i inverts bit b of copy K only at the edge where it is sampled. The inverted value is taken from the next-state value of that copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Shared asynchronous reset, active low |
| load_i | input | 1 | Write data_i at this edge when high |
| data_i | input | W | New value to store |
| flip0_i | input | W | XOR mask into copy 0 at this edge |
| flip1_i | input | W | XOR mask into copy 1 at this edge |
| flip2_i | input | W | XOR mask into copy 2 at this edge |
| data_o | output | W | Two-of-three voted value |
| mismatch_o | output | 1 | Copies disagree in at least one bit |

## Verification
The bench first runs plain loads and holds to set a fault-free baseline. It then injects single-copy flips during a hold and during a load, which shows whether the vote masks one bad copy. A flip of the same bit in a second copy one cycle later shows whether feedback repaired the first copy, or whether the fault would otherwise accumulate. Scattered flips across all three copies in one edge test bits that vote independently. Overlapping masks in two copies isolate the per-bit majority and the single-fault limit, and the corrupted value is expected to propagate to all copies.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_COPIES = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction
endpackage

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] next_i,
  input  logic [W-1:0] flip_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_VAL;
    else         q_o <= next_i ^ flip_i;
  end
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] c0_i,
  input  logic [W-1:0] c1_i,
  input  logic [W-1:0] c2_i,
  output logic [W-1:0] vote_o,
  output logic         differ_o
);
  logic [W-1:0] bit_differ;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign vote_o[b]     = tmr_pkg::maj3(c0_i[b], c1_i[b], c2_i[b]);
    assign bit_differ[b] = (c0_i[b] != c1_i[b]) | (c1_i[b] != c2_i[b]);
  end

  assign differ_o = |bit_differ;
endmodule

// File: rtl/tmr_reg.sv
module tmr_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RESET_VAL = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] flip0_i,
  input  logic [W-1:0] flip1_i,
  input  logic [W-1:0] flip2_i,
  output logic [W-1:0] data_o,
  output logic         mismatch_o
);
  localparam int unsigned NC = tmr_pkg::NUM_COPIES;

  logic [W-1:0] flip [NC];
  logic [W-1:0] copy [NC];
  logic [W-1:0] next_val;

  assign flip[0] = flip0_i;
  assign flip[1] = flip1_i;
  assign flip[2] = flip2_i;

  // feedback: hold reloads the voted value, not the copy's own value
  assign next_val = load_i ? data_i : data_o;

  for (genvar k = 0; k < NC; k++) begin : g_copy
    tmr_copy #(.W(W), .RESET_VAL(RESET_VAL)) i_copy (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .next_i (next_val),
      .flip_i (flip[k]),
      .q_o    (copy[k])
    );
  end

  tmr_vote #(.W(W)) i_vote (
    .c0_i     (copy[0]),
    .c1_i     (copy[1]),
    .c2_i     (copy[2]),
    .vote_o   (data_o),
    .differ_o (mismatch_o)
  );
endmodule

// File: rtl/tmr_reg_chk.sv
module tmr_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] flip0_i,
  input logic [W-1:0] flip1_i,
  input logic [W-1:0] flip2_i,
  input logic [W-1:0] data_o,
  input logic         mismatch_o
);
  logic [W-1:0] dbl;
  logic         none;
  assign dbl  = (flip0_i & flip1_i) | (flip1_i & flip2_i) | (flip0_i & flip2_i);
  assign none = (flip0_i == '0) && (flip1_i == '0) && (flip2_i == '0);

  p_single_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dbl == '0) |=> data_o == $past(data_o));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && dbl == '0) |=> data_o == $past(data_i));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip0_i != '0 && flip1_i == '0 && flip2_i == '0) |=> mismatch_o);

  p_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none |=> !mismatch_o);

  p_double_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mismatch_o && flip0_i == flip1_i && flip0_i != '0 && flip2_i == '0)
      |=> data_o == ($past(data_o) ^ $past(flip0_i)));
endmodule

bind tmr_reg tmr_reg_chk #(.W(W)) i_tmr_reg_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .data_i     (data_i),
  .flip0_i    (flip0_i),
  .flip1_i    (flip1_i),
  .flip2_i    (flip2_i),
  .data_o     (data_o),
  .mismatch_o (mismatch_o)
);

// File: tb/test_tmr_reg.sv
module test_tmr_reg;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] RV = 8'hA5;

  typedef struct {
    logic [W-1:0] d;
    logic         m;
    string        req;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] flip0_i = '0, flip1_i = '0, flip2_i = '0;
  logic [W-1:0] data_o;
  logic         mismatch_o;

  int checks = 0;
  int errors = 0;
  item_t q[$];
  logic [W-1:0] m [3];
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tmr_reg #(.W(W), .RESET_VAL(RV)) i_tmr_reg (
    .clk_i, .rst_ni, .load_i, .data_i, .flip0_i, .flip1_i, .flip2_i,
    .data_o, .mismatch_o
  );

  function automatic logic [W-1:0] vote3(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  task automatic check(string req, logic [W-1:0] act_d, logic [W-1:0] exp_d, logic act_m, logic exp_m);
    checks++;
    if (act_d !== exp_d || act_m !== exp_m) begin
      errors++;
      $display("FAIL %s: data_o=%h mismatch_o=%b, expected %h %b", req, act_d, act_m, exp_d, exp_m);
    end
  endtask

  // driver: drive on negedge, model the copies, queue the expected result
  task automatic step(logic ld, logic [W-1:0] d, logic [W-1:0] f0, logic [W-1:0] f1,
                      logic [W-1:0] f2, string req);
    logic [W-1:0] nxt;
    item_t it;
    @(negedge clk_i);
    load_i = ld; data_i = d; flip0_i = f0; flip1_i = f1; flip2_i = f2;
    nxt  = ld ? d : vote3(m[0], m[1], m[2]);
    m[0] = nxt ^ f0; m[1] = nxt ^ f1; m[2] = nxt ^ f2;
    it.d = vote3(m[0], m[1], m[2]);
    it.m = (m[0] != m[1]) || (m[1] != m[2]);
    it.req = req;
    q.push_back(it);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.req, data_o, it.d, mismatch_o, it.m);
    end
  end

  initial begin
    m[0] = RV; m[1] = RV; m[2] = RV;
    repeat (3) @(negedge clk_i);
    check("R1", data_o, RV, mismatch_o, 1'b0);
    rst_ni = 1'b1;
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R3 hold after reset");
    step(1'b1, 8'h3C, 8'h00, 8'h00, 8'h00, "R2 load");
    step(1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, "R3 hold");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R3 hold");
    step(1'b0, 8'h00, 8'h01, 8'h00, 8'h00, "R5/R7 single upset copy0");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R6/R7 repair clears flag");
    step(1'b0, 8'h00, 8'h00, 8'h01, 8'h00, "R6 same bit other copy masked");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R6 repair");
    step(1'b1, 8'hC3, 8'h00, 8'h00, 8'h0F, "R5/R10 upset on load");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R10 mask one edge only");
    step(1'b0, 8'h00, 8'h01, 8'h02, 8'h04, "R8 scattered upsets");
    step(1'b0, 8'h00, 8'h00, 8'h04, 8'h00, "R8 no accumulation");
    step(1'b0, 8'h00, 8'h02, 8'h00, 8'h00, "R8 no accumulation");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h01, "R8 no accumulation");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R8 settled");
    step(1'b1, 8'h00, 8'h00, 8'h00, 8'h00, "R2 load zero");
    step(1'b0, 8'h00, 8'h0F, 8'h33, 8'h00, "R4 overlap masks");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R4/R9 settled");
    step(1'b0, 8'h00, 8'h80, 8'h80, 8'h00, "R9 double upset");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R9 corruption spreads");
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R9 stays");
    @(negedge clk_i);
    load_i = 1'b0; flip0_i = '0; flip1_i = '0; flip2_i = '0;
    repeat (2) @(negedge clk_i);
    // explicit single-fault-limit checks, independent of the model
    check("R9", data_o, 8'h83, mismatch_o, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R1", data_o, RV, mismatch_o, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule